// File: doc/BRIEF.md
# Display Control Register Bank with Bit-Alias Addressing

This block holds the software-visible control state of a raster display controller on a single-cycle register bus. Four 32-bit registers are implemented: a main control word, an auxiliary control word, a current scan-out buffer address and a pending buffer address. Each register has four byte addresses. One replaces the word. One ORs bits in, one removes bits, and one inverts bits. Software can therefore change a single field without a read-modify-write cycle.

Some behaviour is autonomous, apart from the bus. If scanning is stopped while the pending-data FIFO still holds pixels, the run flag stays set until that FIFO reports empty. Only then does it drop by itself. A write to the FIFO-flush request bit produces a single-cycle flush strobe and leaves nothing stored. The pending buffer address can be written at any moment. It becomes the scan-out address only on a frame strobe, so a page flip never tears the picture. A soft-reset bit in the control word holds the whole bank in its reset state while it is set.

Top module: `disp_regbank`

## Requirements
- R1: A write to register offset 0 (addr[3:2]=0) replaces the register with the written word.
- R2: A write to offset 4 (addr[3:2]=1) ORs the written bits into the register.
- R3: A write to offset 8 (addr[3:2]=2) clears the register bits that are set in the written word.
- R4: A write to offset 12 (addr[3:2]=3) XORs the written bits into the register.
- R5: addr[5:4] selects the register: 0 is main control, 1 is auxiliary control, 2 is current buffer, 3 is pending buffer. A read returns the register value combinationally, the same for all four alias offsets. addr[1:0] is ignored. Any address with a nonzero bit above bit 5 reads zero, and a write to it changes nothing.
- R6: After reset, the main control word is 0x4000_0000 (clock-gate bit 30 set) and every other register is zero. The outputs reflect control fields: soft reset bit 31, clock gate bit 30, dotclock mode bit 17, bus width bits 11:10, word length bits 9:8 and run bit 0.
- R7: A control write whose result has bit 31 set loads the control word with 0x8000_0000 | 0x4000_0000. While bit 31 is set, the bank behaves as follows:
  - From the next clock edge, the other registers are held at zero.
  - Writes to other registers are ignored.
  - Control writes that keep bit 31 change nothing else.
  - A control write that clears bit 31 leaves the word at 0x4000_0000.
- R8: When run (bit 0) is set and dotclock mode (bit 17) is clear, run stays set while fifo_empty_i is low. It clears at the first clock edge with fifo_empty_i high. A control write in that same cycle takes precedence.
- R9: Bit 21 of the auxiliary register is a FIFO-flush request. A write whose result has it set drives fifo_clr_o high for exactly the following cycle. The bit always reads back zero. The other auxiliary bits are stored normally.
- R10: The current-buffer register ignores bus writes. At each clock edge with frame_sync_i high, it loads the pending-buffer value held before that edge, even if the pending register is written in the same cycle. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte address |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| fifo_empty_i | input | 1 | Downstream pixel FIFO has drained |
| frame_sync_i | input | 1 | Frame boundary strobe |
| soft_rst_o | output | 1 | Control bit 31 |
| clk_gate_o | output | 1 | Control bit 30 |
| dotclk_mode_o | output | 1 | Control bit 17 |
| run_o | output | 1 | Control bit 0 |
| bus_width_o | output | 2 | Control bits 11:10 |
| word_len_o | output | 2 | Control bits 9:8 |
| fifo_clr_o | output | 1 | One-cycle FIFO flush strobe |
| cur_buf_o | output | 32 | Active scan-out buffer address |

## Verification
The hardest situations to reach from the ports involve several events in one cycle. One is a pending-buffer write that coincides with a frame strobe. Another is a control write that coincides with the drained FIFO while run is waiting to drop. A third is the handling of writes while soft reset is held. Directed sequences set each of these up explicitly. A long random run then drives every alias, including unmapped addresses and occasional soft-reset writes, with random FIFO-empty and frame-strobe levels. A cycle-level reference model in the bench predicts every output and the read value of the presented address in every cycle.

// File: rtl/disp_regbank_pkg.sv
package disp_regbank_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_REGS   = 4;
  localparam int REG_IDX_W  = $clog2(NUM_REGS);
  localparam int OP_LSB     = 2;
  localparam int IDX_LSB    = 4;
  localparam int MAP_BITS   = IDX_LSB + REG_IDX_W;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_AUX    = 1;
  localparam int IDX_CUR    = 2;
  localparam int IDX_NEXT   = 3;

  localparam int B_SRST     = 31;
  localparam int B_CLKGATE  = 30;
  localparam int B_DOTCLK   = 17;
  localparam int B_BW_LSB   = 10;
  localparam int B_WL_LSB   = 8;
  localparam int B_RUN      = 0;
  localparam int B_FIFO_CLR = 21;

  localparam logic [DATA_W-1:0] CTRL_RST  = DATA_W'(1) << B_CLKGATE;
  localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << B_SRST;
  localparam logic [DATA_W-1:0] FCLR_MASK = DATA_W'(1) << B_FIFO_CLR;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  function automatic logic [DATA_W-1:0] apply_alias(alias_op_e op,
                                                    logic [DATA_W-1:0] old_v,
                                                    logic [DATA_W-1:0] wd);
    case (op)
      OP_SET:  return old_v | wd;
      OP_CLR:  return old_v & ~wd;
      OP_TOG:  return old_v ^ wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import disp_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  output logic                 hit_o,
  output logic [REG_IDX_W-1:0] idx_o,
  output alias_op_e            op_o,
  output logic [NUM_REGS-1:0]  wr_sel_o
);
  logic unused_low;
  assign unused_low = ^addr_i[OP_LSB-1:0];

  generate
    if (ADDR_W > MAP_BITS) begin : g_upper
      assign hit_o = (addr_i[ADDR_W-1:MAP_BITS] == '0);
    end else begin : g_full
      assign hit_o = 1'b1;
    end
  endgenerate

  assign idx_o = addr_i[MAP_BITS-1:IDX_LSB];
  assign op_o  = alias_op_e'(addr_i[IDX_LSB-1:OP_LSB]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel_o[g] = wr_en_i & hit_o & (idx_o == REG_IDX_W'(g));
  end
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import disp_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  alias_op_e         op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fifo_empty_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q, d, res;

  always_comb begin
    res = apply_alias(op_i, q, wdata_i);
    d   = q;
    if (wr_i) begin
      if (res[B_SRST])     d = CTRL_RST | SRST_MASK;
      else if (q[B_SRST])  d = CTRL_RST;
      else                 d = res;
    end else if (!q[B_SRST] && q[B_RUN] && !q[B_DOTCLK] && fifo_empty_i) begin
      d[B_RUN] = 1'b0;  // drained: stop
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= CTRL_RST;
    else         q <= d;
  end

  assign q_o = q;

  assert_run_selfclear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q[B_RUN] && !q[B_DOTCLK] && fifo_empty_i && !wr_i) |=> !q[B_RUN]);

  assert_run_waits_drain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q[B_RUN] && !fifo_empty_i && !wr_i) |=> q[B_RUN]);

  assert_srst_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q[B_SRST] |-> (q == (CTRL_RST | SRST_MASK)));
endmodule

// File: rtl/regbank_aux.sv
module regbank_aux
  import disp_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  alias_op_e         op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              srst_i,
  output logic [DATA_W-1:0] q_o,
  output logic              clr_pulse_o
);
  logic [DATA_W-1:0] q, res;
  logic              pulse;

  assign res = apply_alias(op_i, q, wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= '0;
      pulse <= 1'b0;
    end else if (srst_i) begin
      q     <= '0;
      pulse <= 1'b0;
    end else if (wr_i) begin
      q     <= res & ~FCLR_MASK;  // request bit is not stored
      pulse <= res[B_FIFO_CLR];
    end else begin
      pulse <= 1'b0;
    end
  end

  assign q_o         = q;
  assign clr_pulse_o = pulse;

  assert_fifo_pulse_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_pulse_o |-> ($past(wr_i) && !$past(srst_i)));

  assert_set_alias_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == OP_SET && !srst_i) |=>
      ((q & $past(wdata_i & ~FCLR_MASK)) == $past(wdata_i & ~FCLR_MASK)));

  assert_clr_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == OP_CLR && !srst_i) |=> ((q & $past(wdata_i)) == '0));
endmodule

// File: rtl/regbank_bufptr.sv
module regbank_bufptr
  import disp_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_next_i,
  input  alias_op_e         op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              frame_sync_i,
  input  logic              srst_i,
  output logic [DATA_W-1:0] cur_o,
  output logic [DATA_W-1:0] next_o
);
  logic [DATA_W-1:0] cur_q, next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      next_q <= '0;
    end else if (srst_i) begin
      cur_q  <= '0;
      next_q <= '0;
    end else begin
      if (frame_sync_i) cur_q <= next_q;
      if (wr_next_i)    next_q <= apply_alias(op_i, next_q, wdata_i);
    end
  end

  assign cur_o  = cur_q;
  assign next_o = next_q;

  assert_swap_on_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_sync_i && !srst_i) |=> (cur_o == $past(next_o)));

  assert_cur_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_sync_i && !srst_i) |=> $stable(cur_o));
endmodule

// File: rtl/disp_regbank.sv
module disp_regbank
  import disp_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              fifo_empty_i,
  input  logic              frame_sync_i,
  output logic              soft_rst_o,
  output logic              clk_gate_o,
  output logic              dotclk_mode_o,
  output logic              run_o,
  output logic [1:0]        bus_width_o,
  output logic [1:0]        word_len_o,
  output logic              fifo_clr_o,
  output logic [31:0]       cur_buf_o
);
  logic                 hit;
  logic [REG_IDX_W-1:0] idx;
  alias_op_e            op;
  logic [NUM_REGS-1:0]  wr_sel;
  logic [DATA_W-1:0]    words [NUM_REGS];
  logic [DATA_W-1:0]    ctrl_q, aux_q, cur_q, next_q;
  logic                 srst;

  regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .hit_o    (hit),
    .idx_o    (idx),
    .op_o     (op),
    .wr_sel_o (wr_sel)
  );

  regbank_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_sel[IDX_CTRL]),
    .op_i         (op),
    .wdata_i      (wdata_i),
    .fifo_empty_i (fifo_empty_i),
    .q_o          (ctrl_q)
  );

  assign srst = ctrl_q[B_SRST];

  regbank_aux u_aux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_sel[IDX_AUX] & ~srst),
    .op_i        (op),
    .wdata_i     (wdata_i),
    .srst_i      (srst),
    .q_o         (aux_q),
    .clr_pulse_o (fifo_clr_o)
  );

  regbank_bufptr u_bufptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_next_i    (wr_sel[IDX_NEXT] & ~srst),
    .op_i         (op),
    .wdata_i      (wdata_i),
    .frame_sync_i (frame_sync_i),
    .srst_i       (srst),
    .cur_o        (cur_q),
    .next_o       (next_q)
  );

  // current-buffer slot has no write path
  logic unused_cur_wr;
  assign unused_cur_wr = wr_sel[IDX_CUR];

  assign words[IDX_CTRL] = ctrl_q;
  assign words[IDX_AUX]  = aux_q;
  assign words[IDX_CUR]  = cur_q;
  assign words[IDX_NEXT] = next_q;

  assign rdata_o = hit ? words[idx] : '0;

  assign soft_rst_o    = ctrl_q[B_SRST];
  assign clk_gate_o    = ctrl_q[B_CLKGATE];
  assign dotclk_mode_o = ctrl_q[B_DOTCLK];
  assign run_o         = ctrl_q[B_RUN];
  assign bus_width_o   = ctrl_q[B_BW_LSB+1:B_BW_LSB];
  assign word_len_o    = ctrl_q[B_WL_LSB+1:B_WL_LSB];
  assign cur_buf_o     = cur_q;

  assert_srst_clears_bank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_o && $past(soft_rst_o)) |-> (cur_buf_o == '0 && !fifo_clr_o && !run_o));
endmodule

// File: tb/test_disp_regbank.sv
module test_disp_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wdata, rdata, cur_buf;
  logic        fifo_empty, frame_sync;
  logic        soft_rst, clk_gate, dotclk_mode, run, fifo_clr;
  logic [1:0]  bus_width, word_len;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_ctrl, m_aux, m_cur, m_next;
  logic        m_pulse;

  disp_regbank #(.ADDR_W(8)) i_disp_regbank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .fifo_empty_i(fifo_empty),
    .frame_sync_i(frame_sync), .soft_rst_o(soft_rst), .clk_gate_o(clk_gate),
    .dotclk_mode_o(dotclk_mode), .run_o(run), .bus_width_o(bus_width),
    .word_len_o(word_len), .fifo_clr_o(fifo_clr), .cur_buf_o(cur_buf)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] f_alias(input logic [1:0] op,
                                          input logic [31:0] o, input logic [31:0] w);
    case (op)
      2'd1:    return o | w;
      2'd2:    return o & ~w;
      2'd3:    return o ^ w;
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] f_read(input logic [7:0] a);
    if (a[7:6] != 2'd0) return 32'h0;
    case (a[5:4])
      2'd0:    return m_ctrl;
      2'd1:    return m_aux;
      2'd2:    return m_cur;
      default: return m_next;
    endcase
  endfunction

  task automatic check_outs(input string tag);
    chk(tag, "soft_rst",  {31'd0, soft_rst},    {31'd0, m_ctrl[31]});
    chk(tag, "clk_gate",  {31'd0, clk_gate},    {31'd0, m_ctrl[30]});
    chk(tag, "dotclk",    {31'd0, dotclk_mode}, {31'd0, m_ctrl[17]});
    chk(tag, "run",       {31'd0, run},         {31'd0, m_ctrl[0]});
    chk(tag, "bus_width", {30'd0, bus_width},   {30'd0, m_ctrl[11:10]});
    chk(tag, "word_len",  {30'd0, word_len},    {30'd0, m_ctrl[9:8]});
    chk(tag, "fifo_clr",  {31'd0, fifo_clr},    {31'd0, m_pulse});
    chk(tag, "cur_buf",   cur_buf,              m_cur);
  endtask

  // one bus cycle: drive at negedge, check read, advance model, check outputs
  task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] w,
                     input logic emp, input logic fs, input string tag);
    logic [31:0] r, n_ctrl, n_aux, n_cur, n_next;
    logic        n_pulse, srst, hw;
    addr = a; wr_en = wr; wdata = w; fifo_empty = emp; frame_sync = fs;
    #1;
    chk(tag, "rdata", rdata, f_read(a));
    srst = m_ctrl[31];
    hw   = wr && (a[7:6] == 2'd0);
    n_ctrl = m_ctrl;
    if (hw && a[5:4] == 2'd0) begin
      r = f_alias(a[3:2], m_ctrl, w);
      if (r[31])     n_ctrl = 32'hC000_0000;
      else if (srst) n_ctrl = 32'h4000_0000;
      else           n_ctrl = r;
    end else if (!srst && m_ctrl[0] && !m_ctrl[17] && emp) begin
      n_ctrl[0] = 1'b0;
    end
    n_aux = m_aux; n_pulse = 1'b0;
    n_cur = m_cur; n_next = m_next;
    if (srst) begin
      n_aux = 0; n_cur = 0; n_next = 0;
    end else begin
      if (hw && a[5:4] == 2'd1) begin
        r = f_alias(a[3:2], m_aux, w);
        n_aux = r & ~(32'd1 << 21);
        n_pulse = r[21];
      end
      if (fs) n_cur = m_next;
      if (hw && a[5:4] == 2'd3) n_next = f_alias(a[3:2], m_next, w);
    end
    @(posedge clk);
    @(negedge clk);
    m_ctrl = n_ctrl; m_aux = n_aux; m_pulse = n_pulse; m_cur = n_cur; m_next = n_next;
    check_outs(tag);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    rst_n = 1'b0; addr = 0; wr_en = 0; wdata = 0; fifo_empty = 0; frame_sync = 0;
    m_ctrl = 32'h4000_0000; m_aux = 0; m_cur = 0; m_next = 0; m_pulse = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R6 reset state
    check_outs("R6");
    for (int i = 0; i < 4; i++) begin
      addr = 8'(i * 16);
      #1 chk("R6", "reset read", rdata, (i == 0) ? 32'h4000_0000 : 32'h0);
    end

    // R1 plain write: mode=1, bw=2, wl=3, run=1
    cyc(1, 8'h00, 32'h0002_0B01, 0, 0, "R1");
    chk("R1", "ctrl word", {20'd0, bus_width, word_len, 8'd0}, 32'h0000_0B00);
    // R2 set alias, R3 clear alias, R4 toggle alias
    cyc(1, 8'h14, 32'h0000_00F0, 0, 0, "R2");
    cyc(1, 8'h14, 32'h0000_0F00, 0, 0, "R2");
    cyc(1, 8'h18, 32'h0000_0330, 0, 0, "R3");
    cyc(1, 8'h1C, 32'h0000_00FF, 0, 0, "R4");
    cyc(0, 8'h10, 0, 0, 0, "R4");
    chk("R4", "aux after ops", m_aux, 32'h0000_0C3F);

    // R5 alias read equivalence, low bits ignored, unmapped
    for (int k = 0; k < 4; k++) cyc(0, 8'(8'h10 + k * 4 + k), 0, 0, 0, "R5");
    cyc(1, 8'h44, 32'hFFFF_FFFF, 0, 0, "R5");
    cyc(1, 8'hC0, 32'hFFFF_FFFF, 0, 0, "R5");
    cyc(0, 8'h00, 0, 0, 0, "R5");

    // R8: dotclock set, FIFO empty: run stays
    cyc(0, 8'h00, 0, 1, 0, "R8");
    chk("R8", "run held in dotclock mode", {31'd0, run}, 32'd1);
    cyc(1, 8'h08, 32'h0002_0000, 0, 0, "R8");
    cyc(0, 8'h00, 0, 0, 0, "R8");
    cyc(0, 8'h00, 0, 0, 0, "R8");
    chk("R8", "run waits for drain", {31'd0, run}, 32'd1);
    cyc(1, 8'h04, 32'h0000_0010, 1, 0, "R8");  // write wins over self-clear
    chk("R8", "write beats clear", {31'd0, run}, 32'd1);
    cyc(0, 8'h00, 0, 1, 0, "R8");
    chk("R8", "run cleared", {31'd0, run}, 32'd0);

    // R9 FIFO flush strobe
    cyc(1, 8'h14, 32'h0020_0001, 0, 0, "R9");
    chk("R9", "strobe", {31'd0, fifo_clr}, 32'd1);
    cyc(0, 8'h10, 0, 0, 0, "R9");
    chk("R9", "strobe one cycle", {31'd0, fifo_clr}, 32'd0);
    chk("R9", "request reads zero", {31'd0, rdata[21]}, 32'd0);

    // R10 pointer swap
    cyc(1, 8'h30, 32'h1000_0000, 0, 0, "R10");
    cyc(1, 8'h20, 32'hDEAD_BEEF, 0, 0, "R10");
    chk("R10", "cur ignores write", cur_buf, 32'h0);
    cyc(1, 8'h30, 32'h2000_0000, 0, 1, "R10");
    chk("R10", "swap takes old next", cur_buf, 32'h1000_0000);
    cyc(0, 8'h30, 0, 0, 0, "R10");
    chk("R10", "hold without strobe", cur_buf, 32'h1000_0000);
    cyc(0, 8'h30, 0, 0, 1, "R10");
    chk("R10", "second swap", cur_buf, 32'h2000_0000);

    // R7 soft reset
    cyc(1, 8'h04, 32'h8000_0000, 0, 0, "R7");
    cyc(1, 8'h34, 32'h0000_0FFF, 0, 1, "R7");
    cyc(1, 8'h00, 32'h8000_0F01, 0, 0, "R7");
    cyc(0, 8'h30, 0, 0, 0, "R7");
    chk("R7", "next held zero", rdata, 32'h0);
    chk("R7", "cur held zero", cur_buf, 32'h0);
    cyc(1, 8'h08, 32'h8000_0000, 0, 0, "R7");
    chk("R7", "released word", {soft_rst, clk_gate, 29'd0, run}, 32'h4000_0000);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a;
      logic [31:0] w;
      logic [2:0]  sel;
      string       t;
      sel = 3'($urandom % 5);
      a = (sel == 3'd4) ? 8'(8'h40 + ($urandom % 192)) :
          8'({sel[1:0], 2'($urandom % 4), 2'($urandom % 4)});
      w = $urandom;
      if (($urandom % 8) != 0) w[31] = 1'b0;
      case (a[3:2])
        2'd0: t = "R1";
        2'd1: t = "R2";
        2'd2: t = "R3";
        default: t = "R4";
      endcase
      cyc(1'($urandom % 2), a, w, 1'($urandom % 3 == 0), 1'($urandom % 6 == 0), t);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule